// File: doc/BRIEF.md
# Flash-to-Memory Read DMA Engine

This block copies a contiguous region of serial flash into system memory. Software writes a flash source address, a destination start address and a destination end address, then sets the go bit in the control register. The engine asks a read-frame sequencer for one 16-byte frame at a time. It gathers the returned byte stream into a 16-byte beat and writes that beat to a memory write port with a valid/ready handshake. Each beat moves the destination address up by 16.

The transfer ends when the next destination address reaches the end address. The go bit then reads back as zero, and the completion bit in an 8-bit interrupt status register is set. The interrupt output is the registered AND of status and enable. Software clears status by writing back the bits it wants cleared. Destination addresses are 36 bits wide, so a separate high-word register holds the upper bits of each destination address.

Top module: `flash_rd_dma`

## Requirements
- R1: After reset every register reads 0, `reg_rdata` is 0, and `frm_req_valid`, `mw_valid` and `irq` are 0.
- R2: The register word offsets are 0 control, 1 flash source, 2 destination start low, 3 destination start high, 4 destination end low, 5 destination end high, 6 interrupt status and 7 interrupt enable. Each register reads back what was written, except as follows. The two high words keep only bits 3:0. The enable register keeps bits 7:0. Status cannot be set by a write. A read returns its data on `reg_rdata` one cycle after `reg_rd_en`.
- R3: Writing a 1 to control bit 0 while idle starts a transfer. Control bit 0 reads 1 while the transfer runs and 0 once it has finished.
- R4: Writing the go bit while a transfer runs has no effect: the transfer carries on with its original addresses and beat count.
- R5: Each beat is preceded by exactly one frame request. The request address is the aligned source plus 16 times the beat index. The first byte received lands in bits 7:0 of the beat, and byte k lands in bits 8k+7:8k.
- R6: The first beat goes to the aligned destination start, and each later beat goes 16 bytes higher. A beat waiting for `mw_ready` keeps its address and data unchanged.
- R7: A transfer writes exactly (end − start)/16 beats, using the aligned addresses, and stops once the next destination address reaches the end address.
- R8: If the aligned end address is not greater than the aligned start address, the transfer completes with no frame request and no memory write, and it still sets the completion status.
- R9: Completion sets status bit 7 on the same clock edge on which control bit 0 returns to 0. This happens only after the last beat has been accepted.
- R10: Writing a value to the status register clears exactly the status bits that are 1 in that value. Bits written as 0 stay as they were.
- R11: `irq` is 1 one cycle after a status bit and its matching enable bit are both 1, and returns to 0 one cycle after that condition ends.
- R12: Bits 3:0 of the source, destination start and end addresses are ignored and treated as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| frm_req_valid | output | 1 | Frame request to the sequencer |
| frm_req_ready | input | 1 | Sequencer accepts the frame request |
| frm_req_addr | output | 32 | Flash address of the requested frame |
| sb_valid | input | 1 | Byte from the sequencer is valid |
| sb_byte | input | 8 | Received flash byte |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory accepts the beat |
| mw_addr | output | 36 | Destination address of the beat |
| mw_data | output | 128 | Beat data, first byte in bits 7:0 |
| irq | output | 1 | Interrupt output |

## Verification
The checks assume that the sequencer sends exactly 16 bytes, and only after a frame request has been accepted. They also assume that software keeps the end address from wrapping past the top of the 36-bit space. The bench's sequencer model answers each request with exactly 16 bytes, inserting random gaps between them. Random destinations keep bit 35 clear and transfers short, so end addresses never wrap. Memory ready is driven at random and depends on nothing else.

// File: rtl/flash_rd_dma_pkg.sv
package flash_rd_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_RECV  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } eng_state_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_FSRC  = 3'd1;
  localparam logic [2:0] RA_DLO   = 3'd2;
  localparam logic [2:0] RA_DHI   = 3'd3;
  localparam logic [2:0] RA_ELO   = 3'd4;
  localparam logic [2:0] RA_EHI   = 3'd5;
  localparam logic [2:0] RA_ISTAT = 3'd6;
  localparam logic [2:0] RA_IEN   = 3'd7;

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
  import flash_rd_dma_pkg::*;
#(
  parameter int unsigned ADDR_W   = 36,
  parameter int unsigned FADDR_W  = 32,
  parameter int unsigned IRQ_W    = 8,
  parameter int unsigned DONE_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic               busy,
  input  logic               done_evt,
  output logic               start_o,
  output logic [FADDR_W-1:0] fsrc_o,
  output logic [ADDR_W-1:0]  dst_o,
  output logic [ADDR_W-1:0]  end_o,
  output logic [IRQ_W-1:0]   stat_o,
  output logic [IRQ_W-1:0]   en_o,
  output logic               irq_o
);

  localparam logic [31:0] HI_MASK = (ADDR_W > 32) ?
    32'((64'd1 << (ADDR_W - 32)) - 64'd1) : 32'd0;
  localparam logic [IRQ_W-1:0] DONE_MASK =
    {{(IRQ_W-1){1'b0}}, 1'b1} << DONE_BIT;

  logic [FADDR_W-1:0] fsrc_q;
  logic [31:0]        dlo_q, dhi_q, elo_q, ehi_q;
  logic [IRQ_W-1:0]   stat_q, en_q, clr_mask, set_mask;
  logic               irq_q;
  logic [31:0]        rdata_q, rd_mux;

  assign start_o = wr_en && (addr == RA_CTRL) && wdata[0] && !busy;
  assign clr_mask = (wr_en && addr == RA_ISTAT) ? wdata[IRQ_W-1:0] : '0;
  assign set_mask = done_evt ? DONE_MASK : '0;

  always_comb begin
    case (addr)
      RA_CTRL:  rd_mux = {31'd0, busy};
      RA_FSRC:  rd_mux = 32'(fsrc_q);
      RA_DLO:   rd_mux = dlo_q;
      RA_DHI:   rd_mux = dhi_q;
      RA_ELO:   rd_mux = elo_q;
      RA_EHI:   rd_mux = ehi_q;
      RA_ISTAT: rd_mux = 32'(stat_q);
      default:  rd_mux = 32'(en_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsrc_q  <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      elo_q   <= '0;
      ehi_q   <= '0;
      en_q    <= '0;
      stat_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          RA_FSRC: fsrc_q <= wdata[FADDR_W-1:0];
          RA_DLO:  dlo_q  <= wdata;
          RA_DHI:  dhi_q  <= wdata & HI_MASK;
          RA_ELO:  elo_q  <= wdata;
          RA_EHI:  ehi_q  <= wdata & HI_MASK;
          RA_IEN:  en_q   <= wdata[IRQ_W-1:0];
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~clr_mask) | set_mask;
      irq_q  <= |(stat_q & en_q);
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign fsrc_o = fsrc_q;
  assign dst_o  = ADDR_W'({dhi_q, dlo_q});
  assign end_o  = ADDR_W'({ehi_q, elo_q});
  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/fdma_packer.sv
module fdma_packer #(
  parameter int unsigned BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    clr,
  input  logic                    in_valid,
  input  logic [7:0]              in_byte,
  output logic                    full_o,
  output logic [BEAT_BYTES*8-1:0] data_o
);

  localparam int unsigned IDX_W = $clog2(BEAT_BYTES);

  logic [IDX_W-1:0] cnt_q;
  logic             full_q;
  logic             take;

  assign take = en && in_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      if (cnt_q == IDX_W'(BEAT_BYTES - 1)) begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (take && cnt_q == IDX_W'(g)) lane_q <= in_byte;
    end
    assign data_o[g*8 +: 8] = lane_q;
  end

  assign full_o = full_q;

endmodule

// File: rtl/fdma_engine.sv
module fdma_engine
  import flash_rd_dma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 36,
  parameter int unsigned FADDR_W    = 32,
  parameter int unsigned BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [FADDR_W-1:0]      fsrc_in,
  input  logic [ADDR_W-1:0]       dst_in,
  input  logic [ADDR_W-1:0]       end_in,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [FADDR_W-1:0]      req_addr_o,
  output logic                    pk_en_o,
  output logic                    pk_clr_o,
  input  logic                    pk_full_i,
  input  logic [BEAT_BYTES*8-1:0] pk_data_i,
  output logic                    mw_valid_o,
  input  logic                    mw_ready_i,
  output logic [ADDR_W-1:0]       mw_addr_o,
  output logic [BEAT_BYTES*8-1:0] mw_data_o
);

  localparam logic [ADDR_W-1:0]  D_LOW  = ADDR_W'(BEAT_BYTES - 1);
  localparam logic [FADDR_W-1:0] F_LOW  = FADDR_W'(BEAT_BYTES - 1);
  localparam logic [ADDR_W-1:0]  D_STEP = ADDR_W'(BEAT_BYTES);
  localparam logic [FADDR_W-1:0] F_STEP = FADDR_W'(BEAT_BYTES);

  eng_state_t        state_q;
  logic [FADDR_W-1:0] src_q;
  logic [ADDR_W-1:0]  dst_q, end_q, dst_nx, dst_al, end_al;

  assign dst_al = dst_in & ~D_LOW;
  assign end_al = end_in & ~D_LOW;
  assign dst_nx = dst_q + D_STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      end_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          src_q   <= fsrc_in & ~F_LOW;
          dst_q   <= dst_al;
          end_q   <= end_al;
          state_q <= (end_al > dst_al) ? ST_REQ : ST_FIN;
        end
        ST_REQ:  if (req_ready_i) state_q <= ST_RECV;
        ST_RECV: if (pk_full_i) state_q <= ST_WRITE;
        ST_WRITE: if (mw_ready_i) begin
          dst_q   <= dst_nx;
          src_q   <= src_q + F_STEP;
          state_q <= (dst_nx >= end_q) ? ST_FIN : ST_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign req_valid_o = (state_q == ST_REQ);
  assign req_addr_o  = src_q;
  assign pk_en_o     = (state_q == ST_RECV);
  assign pk_clr_o    = (state_q == ST_WRITE) && mw_ready_i;
  assign mw_valid_o  = (state_q == ST_WRITE);
  assign mw_addr_o   = dst_q;
  assign mw_data_o   = pk_data_i;

endmodule

// File: rtl/flash_rd_dma.sv
module flash_rd_dma #(
  parameter int unsigned ADDR_W     = 36,
  parameter int unsigned FADDR_W    = 32,
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned IRQ_W      = 8,
  parameter int unsigned DONE_BIT   = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr_en,
  input  logic                    reg_rd_en,
  input  logic [2:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    frm_req_valid,
  input  logic                    frm_req_ready,
  output logic [FADDR_W-1:0]      frm_req_addr,
  input  logic                    sb_valid,
  input  logic [7:0]              sb_byte,
  output logic                    mw_valid,
  input  logic                    mw_ready,
  output logic [ADDR_W-1:0]       mw_addr,
  output logic [BEAT_BYTES*8-1:0] mw_data,
  output logic                    irq
);

  logic                    eng_busy, eng_done, go;
  logic [FADDR_W-1:0]      cfg_fsrc;
  logic [ADDR_W-1:0]       cfg_dst, cfg_end;
  logic [IRQ_W-1:0]        irq_stat, irq_en;
  logic                    pk_en, pk_clr, pk_full;
  logic [BEAT_BYTES*8-1:0] pk_data;

  fdma_regs #(
    .ADDR_W(ADDR_W), .FADDR_W(FADDR_W), .IRQ_W(IRQ_W), .DONE_BIT(DONE_BIT)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .busy(eng_busy), .done_evt(eng_done), .start_o(go),
    .fsrc_o(cfg_fsrc), .dst_o(cfg_dst), .end_o(cfg_end),
    .stat_o(irq_stat), .en_o(irq_en), .irq_o(irq)
  );

  fdma_packer #(.BEAT_BYTES(BEAT_BYTES)) pack_i (
    .clk(clk), .rst(rst), .en(pk_en), .clr(pk_clr),
    .in_valid(sb_valid), .in_byte(sb_byte),
    .full_o(pk_full), .data_o(pk_data)
  );

  fdma_engine #(
    .ADDR_W(ADDR_W), .FADDR_W(FADDR_W), .BEAT_BYTES(BEAT_BYTES)
  ) eng_i (
    .clk(clk), .rst(rst), .start(go),
    .fsrc_in(cfg_fsrc), .dst_in(cfg_dst), .end_in(cfg_end),
    .busy_o(eng_busy), .done_o(eng_done),
    .req_valid_o(frm_req_valid), .req_ready_i(frm_req_ready),
    .req_addr_o(frm_req_addr),
    .pk_en_o(pk_en), .pk_clr_o(pk_clr), .pk_full_i(pk_full),
    .pk_data_i(pk_data),
    .mw_valid_o(mw_valid), .mw_ready_i(mw_ready),
    .mw_addr_o(mw_addr), .mw_data_o(mw_data)
  );

endmodule

// File: rtl/flash_rd_dma_chk.sv
module flash_rd_dma_chk #(
  parameter int unsigned ADDR_W     = 36,
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned IRQ_W      = 8,
  parameter int unsigned DONE_BIT   = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic [IRQ_W-1:0]        stat,
  input logic                    frm_req_valid,
  input logic                    mw_valid,
  input logic                    mw_ready,
  input logic [ADDR_W-1:0]       mw_addr,
  input logic [BEAT_BYTES*8-1:0] mw_data
);

  localparam int unsigned SH = $clog2(BEAT_BYTES);

  // R6
  mw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  // R12
  mw_align_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> mw_addr[SH-1:0] == '0);

  // R9
  done_stat_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> stat[DONE_BIT]);

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mw_valid && frm_req_valid));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mw_valid && !frm_req_valid);

endmodule

bind flash_rd_dma flash_rd_dma_chk #(
  .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .IRQ_W(IRQ_W), .DONE_BIT(DONE_BIT)
) chk_i (
  .clk(clk), .rst(rst), .busy(eng_busy), .stat(irq_stat),
  .frm_req_valid(frm_req_valid), .mw_valid(mw_valid), .mw_ready(mw_ready),
  .mw_addr(mw_addr), .mw_data(mw_data)
);

// File: tb/flash_rd_dma_tb_top.sv
module flash_rd_dma_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         reg_wr_en, reg_rd_en;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         frm_req_valid, frm_req_ready;
  logic [31:0]  frm_req_addr;
  logic         sb_valid;
  logic [7:0]   sb_byte;
  logic         mw_valid, mw_ready;
  logic [35:0]  mw_addr;
  logic [127:0] mw_data;
  logic         irq;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  logic [31:0] exp_src0;
  logic [35:0] exp_dst0;
  int exp_beats = 0;
  int req_cnt = 0;
  int beat_cnt = 0;

  always #2 clk = ~clk;

  flash_rd_dma dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_req_valid(frm_req_valid), .frm_req_ready(frm_req_ready),
    .frm_req_addr(frm_req_addr), .sb_valid(sb_valid), .sb_byte(sb_byte),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .irq(irq)
  );

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A ^ {a[3:0], a[19:16]};
  endfunction

  function automatic logic [127:0] beat_of(input logic [31:0] src);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[i*8 +: 8] = fbyte(src + 32'(i));
    return d;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic seq_proc();
    forever begin
      @(negedge clk);
      if (frm_req_valid) begin
        // R5: request address walks the aligned source by 16
        chk(frm_req_addr == exp_src0 + 32'(16 * req_cnt), "R5 req addr",
            128'(frm_req_addr), 128'(exp_src0 + 32'(16 * req_cnt)));
        req_cnt++;
        frm_req_ready = 1'b1;
        @(negedge clk);
        frm_req_ready = 1'b0;
        for (int i = 0; i < 16; i++) begin
          if ($urandom % 3 == 0) @(negedge clk);
          sb_valid = 1'b1;
          sb_byte  = fbyte(frm_req_addr + 32'(i));
          @(negedge clk);
          sb_valid = 1'b0;
        end
      end
    end
  endtask

  task automatic mem_proc();
    forever begin
      bit r;
      @(negedge clk);
      r = ($urandom % 4) != 0;
      if (mw_valid && r) begin
        // R6: destination walks by 16
        chk(mw_addr == exp_dst0 + 36'(16 * beat_cnt), "R6 beat addr",
            128'(mw_addr), 128'(exp_dst0 + 36'(16 * beat_cnt)));
        // R5: byte order inside the beat
        chk(mw_data == beat_of(exp_src0 + 32'(16 * beat_cnt)), "R5 beat data",
            mw_data, beat_of(exp_src0 + 32'(16 * beat_cnt)));
        // R7: no beat past the end
        chk(beat_cnt < exp_beats, "R7 extra beat", 128'(beat_cnt), 128'(exp_beats));
        beat_cnt++;
      end
      mw_ready = r;
    end
  endtask

  task automatic run_xfer(input logic [31:0] src, input logic [35:0] dst,
                          input logic [35:0] fin, input logic [7:0] en,
                          input bit restart);
    logic [31:0] d;
    logic [35:0] dm, em;
    int polls;
    dm = dst & ~36'hF;
    em = fin & ~36'hF;
    exp_src0  = src & ~32'hF;
    exp_dst0  = dm;
    exp_beats = (em > dm) ? int'((em - dm) >> 4) : 0;
    req_cnt = 0;
    beat_cnt = 0;
    reg_write(3'd1, src);
    reg_write(3'd2, dst[31:0]);
    reg_write(3'd3, {28'd0, dst[35:32]});
    reg_write(3'd4, fin[31:0]);
    reg_write(3'd5, {28'd0, fin[35:32]});
    reg_write(3'd7, {24'd0, en});
    reg_write(3'd0, 32'd1);
    if (exp_beats > 0) begin
      reg_read(3'd0, d);
      chk(d == 32'd1, "R3 busy reads 1", 128'(d), 128'd1);
      if (restart) begin
        repeat (5) @(negedge clk);
        // R4: second go while busy must not restart
        reg_write(3'd0, 32'd1);
      end
    end
    polls = 0;
    do begin
      reg_read(3'd0, d);
      polls++;
    end while (d[0] && polls < 2000);
    chk(d == 32'd0, "R3 idle after finish", 128'(d), 128'd0);
    chk(beat_cnt == exp_beats, restart ? "R4 beat count" : "R7 beat count",
        128'(beat_cnt), 128'(exp_beats));
    chk(req_cnt == exp_beats, exp_beats == 0 ? "R8 no request" : "R5 request count",
        128'(req_cnt), 128'(exp_beats));
    reg_read(3'd6, d);
    chk(d == 32'h80, exp_beats == 0 ? "R8 done status" : "R9 done status",
        128'(d), 128'h80);
    @(negedge clk);
    chk(irq == en[7], "R11 irq follows enable", 128'(irq), 128'(en[7]));
    reg_write(3'd6, 32'h7F);
    reg_read(3'd6, d);
    chk(d == 32'h80, "R10 zero bits keep status", 128'(d), 128'h80);
    reg_write(3'd6, 32'h80);
    reg_read(3'd6, d);
    chk(d == 32'h0, "R10 write-back clears", 128'(d), 128'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R11 irq drops", 128'(irq), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    rst = 1'b1;
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
    frm_req_ready = 0; sb_valid = 0; sb_byte = 0; mw_ready = 0;
    exp_src0 = 0; exp_dst0 = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(!mw_valid && !frm_req_valid && !irq, "R1 outputs idle",
        128'({mw_valid, frm_req_valid, irq}), 128'd0);
    chk(reg_rdata == 0, "R1 rdata", 128'(reg_rdata), 128'd0);
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), d);
      chk(d == 0, "R1 reg reset", 128'(d), 128'd0);
    end
    fork
      seq_proc();
      mem_proc();
    join_none
    // R2 readback
    reg_write(3'd1, 32'hDEADBEEF); reg_read(3'd1, d);
    chk(d == 32'hDEADBEEF, "R2 source", 128'(d), 128'hDEADBEEF);
    reg_write(3'd2, 32'h12345678); reg_read(3'd2, d);
    chk(d == 32'h12345678, "R2 dest low", 128'(d), 128'h12345678);
    reg_write(3'd3, 32'hFFFFFFFF); reg_read(3'd3, d);
    chk(d == 32'hF, "R2 dest high mask", 128'(d), 128'hF);
    reg_write(3'd4, 32'hCAFEF00D); reg_read(3'd4, d);
    chk(d == 32'hCAFEF00D, "R2 end low", 128'(d), 128'hCAFEF00D);
    reg_write(3'd5, 32'hA5); reg_read(3'd5, d);
    chk(d == 32'h5, "R2 end high mask", 128'(d), 128'h5);
    reg_write(3'd7, 32'hFFFFFFFF); reg_read(3'd7, d);
    chk(d == 32'hFF, "R2 enable mask", 128'(d), 128'hFF);
    reg_write(3'd6, 32'hFF); reg_read(3'd6, d);
    chk(d == 32'h0, "R2 status not settable", 128'(d), 128'h0);
    reg_write(3'd7, 32'h0);
    // directed
    run_xfer(32'h100, 36'h9_0000_0040, 36'h9_0000_0080, 8'h80, 0);
    run_xfer(32'h200, 36'h1_0000_0000, 36'h1_0000_0000, 8'h80, 0);      // R8 equal
    run_xfer(32'h200, 36'h1_0000_0100, 36'h1_0000_0040, 8'h00, 0);      // R8 below
    run_xfer(32'h1237, 36'h2_0000_010F, 36'h2_0000_014A, 8'h80, 0);     // R12
    run_xfer(32'h3000, 36'h0_0000_0000, 36'h0_0000_0060, 8'h80, 1);     // R4
    run_xfer(32'h4000, 36'h7_FFFF_FFF0, 36'h8_0000_0010, 8'h80, 0);     // 32-bit carry
    // random
    for (int t = 0; t < 12; t++) begin
      logic [31:0] s;
      logic [35:0] ds;
      int nb;
      s  = $urandom;
      ds = {1'b0, 3'($urandom), 32'($urandom)};
      nb = int'($urandom_range(0, 6));
      run_xfer(s, ds, ds + 36'(16 * nb) + 36'($urandom % 16), 8'($urandom),
               ($urandom % 3) == 0);
    end
    summary();
  end

endmodule